// File: doc/BRIEF.md
# Energy-Spike Clap Detector

The block listens to a stream of signed audio samples that arrive with a valid strobe. It cuts the stream into fixed windows of `WIN_LEN` accepted samples. For each window it adds up the squared samples to get one energy value. A sequencer then walks over the window energies and looks for a clap shape: a loud run, then an optional short middle-level gap, then a quiet run.

The loud run must last at least a minimum number of windows. It may run longer only by a bounded overrun. The gap is bounded in length, and the quiet run has its own minimum length. Both thresholds and all window counts are input ports, so they can be tuned without rebuilding the block.

Each recognised clap gives a one-cycle pulse. A pair tracker measures the spacing between confirmed claps in windows. When two claps fall inside a programmable spacing window, the pair tracker flips a lamp output.

Top module: `clap_energy_detector`

## Requirements
- R1: Every `WIN_LEN` accepted samples (`smp_valid` high), `win_energy` carries the sum of the squared samples of that window, and `win_valid` is high for exactly one cycle. That cycle is the one after the clock edge that accepted the window's last sample. Cycles with `smp_valid` low are not counted.
- R2: The window sum saturates at all ones (2^ENERGY_W − 1) instead of wrapping. With the defaults, four samples of −32768 give 0xFFFFFFFF.
- R3: A window is high when energy ≥ `thr_high`, low when energy ≤ `thr_low`, and middle otherwise. A high run shorter than `min_high` windows rejects the candidate.
- R4: A high run longer than `min_high + max_extra` windows aborts the candidate. After an abort, no clap can start until a window that is not high has been seen.
- R5: Between the high run and the low run, up to `max_gap` middle windows are allowed. One more middle window, or a high window during the gap, rejects the candidate.
- R6: A clap is confirmed when the low run reaches `min_low` windows. `clap_pulse` is then high for one cycle, one cycle after the `win_valid` of that window. A non-low window before that point rejects the candidate.
- R7: When a clap is confirmed, its spacing is the difference, in windows, between this clap's confirming window and the previous clap's confirming window. The window count runs from reset.
- R8: If a clap is pending and the new spacing lies in [`pair_min`, `pair_max`] (inclusive), `lamp_on` toggles in the same cycle as `clap_pulse` and the pending clap is consumed. Otherwise the new clap becomes the single pending clap.
- R9: While `thr_high` ≤ `thr_low`, the sequencer is held idle and no clap is reported. `cfg_err` is a registered copy of that condition.
- R10: A synchronous active-low reset clears the window accumulator, the sequencer, the spacing count, the pending clap, `lamp_on`, `clap_pulse` and `win_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | SAMPLE_W | Signed audio sample |
| thr_high | input | ENERGY_W | Loud threshold (inclusive) |
| thr_low | input | ENERGY_W | Quiet threshold (inclusive) |
| min_high | input | RUN_W | Minimum loud run, windows |
| max_extra | input | RUN_W | Allowed loud overrun, windows |
| max_gap | input | RUN_W | Allowed middle gap, windows |
| min_low | input | RUN_W | Minimum quiet run, windows |
| pair_min | input | SPACE_W | Smallest clap spacing for a pair |
| pair_max | input | SPACE_W | Largest clap spacing for a pair |
| win_valid | output | 1 | Window energy strobe |
| win_energy | output | ENERGY_W | Saturated window energy |
| clap_pulse | output | 1 | One-cycle clap indication |
| lamp_on | output | 1 | Lamp control, toggled by a clap pair |
| cfg_err | output | 1 | Thresholds not ordered |

## Verification
A clap confirmation and a lamp toggle can land on the same clock edge. Whether the lamp flips then depends on the spacing count at that moment. The bench provokes this with clap pairs spaced below the window, exactly at both inclusive edges, and far outside it. A reset is placed between pairs. A behavioural model tracks the spacing as a plain integer, and each cycle `clap_pulse` and `lamp_on` are compared with the model together, so a toggle one cycle off or on the wrong spacing is reported.

// File: rtl/clap_pkg.sv
`timescale 1ns/1ps
// Shared types for the clap detector: sequencer states and energy level classes.
package clap_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_HIGH = 3'd1,
        ST_GAP  = 3'd2,
        ST_LOW  = 3'd3,
        ST_HOLD = 3'd4
    } clap_state_t;

    typedef enum logic [1:0] {
        LVL_LOW  = 2'd0,
        LVL_MID  = 2'd1,
        LVL_HIGH = 2'd2
    } energy_level_t;

endpackage

// File: rtl/energy_window.sv
`timescale 1ns/1ps
// energy_window
// Sums squared signed samples over WIN_LEN accepted samples and emits one
// saturated energy value per window with a one-cycle strobe.
// Assumes WIN_LEN >= 2 and ENERGY_W >= 2*SAMPLE_W.
module energy_window #(
    parameter int SAMPLE_W = 16,
    parameter int WIN_LEN  = 4,
    parameter int ENERGY_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       smp_valid,
    input  logic signed [SAMPLE_W-1:0] smp_data,
    output logic                       win_valid,
    output logic [ENERGY_W-1:0]        win_energy
);
    localparam int SQ_W  = 2 * SAMPLE_W;
    localparam int IDX_W = $clog2(WIN_LEN);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WIN_LEN - 1);

    logic [IDX_W-1:0]    idx;
    logic [ENERGY_W-1:0] acc;
    logic signed [SQ_W-1:0] prod;
    logic [SQ_W-1:0]     sq;
    logic [ENERGY_W:0]   sum_wide;
    logic [ENERGY_W-1:0] sum_sat;

    // Square the incoming sample; the result is never negative.
    always_comb begin
        prod = SQ_W'(smp_data) * SQ_W'(smp_data);
        sq   = prod;
    end

    // Add the square to the running total, clamping at all ones.
    always_comb begin
        sum_wide = {1'b0, acc} + {{(ENERGY_W + 1 - SQ_W){1'b0}}, sq};
        sum_sat  = sum_wide[ENERGY_W] ? {ENERGY_W{1'b1}} : sum_wide[ENERGY_W-1:0];
    end

    // Track the position inside the window and publish the total at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx        <= '0;
            acc        <= '0;
            win_valid  <= 1'b0;
            win_energy <= '0;
        end else begin
            win_valid <= 1'b0;
            if (smp_valid) begin
                if (idx == LAST_IDX) begin
                    idx        <= '0;
                    acc        <= '0;
                    win_valid  <= 1'b1;
                    win_energy <= sum_sat;
                end else begin
                    idx <= idx + 1'b1;
                    acc <= sum_sat;
                end
            end
        end
    end
endmodule

// File: rtl/clap_sequencer.sv
`timescale 1ns/1ps
// clap_sequencer
// Classifies each window energy as high, middle or low and walks the
// high-run / gap / low-run pattern. Raises a combinational confirm in the
// window that completes the low run, and a registered one-cycle pulse after it.
// Assumes e_valid is never high in two consecutive cycles.
module clap_sequencer
    import clap_pkg::*;
#(
    parameter int ENERGY_W = 32,
    parameter int RUN_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_ok,
    input  logic                e_valid,
    input  logic [ENERGY_W-1:0] e_value,
    input  logic [ENERGY_W-1:0] thr_high,
    input  logic [ENERGY_W-1:0] thr_low,
    input  logic [RUN_W-1:0]    min_high,
    input  logic [RUN_W-1:0]    max_extra,
    input  logic [RUN_W-1:0]    max_gap,
    input  logic [RUN_W-1:0]    min_low,
    output logic                confirm,
    output logic                clap_pulse
);
    localparam int CNT_W = RUN_W + 1;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    clap_state_t      st, st_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    energy_level_t    lvl;
    logic [CNT_W-1:0] high_limit;
    logic [CNT_W-1:0] cnt_inc;
    logic             low_immediate;

    // Sort the current window energy into one of three bands.
    always_comb begin
        if (e_value >= thr_high)     lvl = LVL_HIGH;
        else if (e_value <= thr_low) lvl = LVL_LOW;
        else                         lvl = LVL_MID;
    end

    // Derived limits for the run counter.
    always_comb begin
        high_limit    = {1'b0, min_high} + {1'b0, max_extra};
        cnt_inc       = cnt + ONE;
        low_immediate = ({1'b0, min_low} <= ONE);
    end

    // Next-state decision, evaluated only on window strobes.
    always_comb begin
        st_n    = st;
        cnt_n   = cnt;
        confirm = 1'b0;
        if (!cfg_ok) begin
            st_n  = ST_IDLE;
            cnt_n = '0;
        end else if (e_valid) begin
            unique case (st)
                ST_IDLE: begin
                    if (lvl == LVL_HIGH) begin
                        st_n  = ST_HIGH;
                        cnt_n = ONE;
                    end
                end
                ST_HIGH: begin
                    if (lvl == LVL_HIGH) begin
                        if (cnt >= high_limit) begin
                            st_n  = ST_HOLD;
                            cnt_n = '0;
                        end else begin
                            cnt_n = cnt_inc;
                        end
                    end else if (cnt < {1'b0, min_high}) begin
                        st_n  = ST_IDLE;
                        cnt_n = '0;
                    end else if (lvl == LVL_LOW) begin
                        if (low_immediate) begin
                            confirm = 1'b1;
                            st_n    = ST_IDLE;
                            cnt_n   = '0;
                        end else begin
                            st_n  = ST_LOW;
                            cnt_n = ONE;
                        end
                    end else if (max_gap == '0) begin
                        st_n  = ST_IDLE;
                        cnt_n = '0;
                    end else begin
                        st_n  = ST_GAP;
                        cnt_n = ONE;
                    end
                end
                ST_GAP: begin
                    if (lvl == LVL_HIGH) begin
                        st_n  = ST_IDLE;
                        cnt_n = '0;
                    end else if (lvl == LVL_LOW) begin
                        if (low_immediate) begin
                            confirm = 1'b1;
                            st_n    = ST_IDLE;
                            cnt_n   = '0;
                        end else begin
                            st_n  = ST_LOW;
                            cnt_n = ONE;
                        end
                    end else if (cnt >= {1'b0, max_gap}) begin
                        st_n  = ST_IDLE;
                        cnt_n = '0;
                    end else begin
                        cnt_n = cnt_inc;
                    end
                end
                ST_LOW: begin
                    if (lvl == LVL_LOW) begin
                        if (cnt_inc >= {1'b0, min_low}) begin
                            confirm = 1'b1;
                            st_n    = ST_IDLE;
                            cnt_n   = '0;
                        end else begin
                            cnt_n = cnt_inc;
                        end
                    end else begin
                        st_n  = ST_IDLE;
                        cnt_n = '0;
                    end
                end
                ST_HOLD: begin
                    if (lvl != LVL_HIGH) begin
                        st_n  = ST_IDLE;
                        cnt_n = '0;
                    end
                end
                default: begin
                    st_n  = ST_IDLE;
                    cnt_n = '0;
                end
            endcase
        end
    end

    // State, run counter and pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            cnt        <= '0;
            clap_pulse <= 1'b0;
        end else begin
            st         <= st_n;
            cnt        <= cnt_n;
            clap_pulse <= confirm;
        end
    end
endmodule

// File: rtl/clap_pair.sv
`timescale 1ns/1ps
// clap_pair
// Counts windows since the last confirmed clap and toggles the lamp when a
// second clap arrives with spacing inside [pair_min, pair_max].
// Assumes confirm is only high together with e_valid.
module clap_pair #(
    parameter int SPACE_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               e_valid,
    input  logic               confirm,
    input  logic [SPACE_W-1:0] pair_min,
    input  logic [SPACE_W-1:0] pair_max,
    output logic               lamp_on
);
    localparam logic [SPACE_W-1:0] SPACE_MAX = {SPACE_W{1'b1}};

    logic [SPACE_W-1:0] since;
    logic [SPACE_W-1:0] spacing;
    logic               pending;
    logic               in_window;

    // Spacing of a clap confirmed in this window, clamped at the counter top.
    always_comb begin
        spacing   = (since == SPACE_MAX) ? SPACE_MAX : since + 1'b1;
        in_window = (spacing >= pair_min) && (spacing <= pair_max);
    end

    // Window counter, pending-clap flag and lamp register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since   <= '0;
            pending <= 1'b0;
            lamp_on <= 1'b0;
        end else if (e_valid) begin
            if (confirm) begin
                since <= '0;
                if (pending && in_window) begin
                    lamp_on <= ~lamp_on;
                    pending <= 1'b0;
                end else begin
                    pending <= 1'b1;
                end
            end else begin
                since <= spacing;
            end
        end
    end
endmodule

// File: rtl/clap_energy_detector.sv
`timescale 1ns/1ps
// clap_energy_detector
// Top level: window energy, clap pattern sequencer and clap-pair lamp toggle.
// Holds the sequencer idle while the thresholds are not strictly ordered.
// Assumes WIN_LEN >= 2 and ENERGY_W >= 2*SAMPLE_W.
module clap_energy_detector #(
    parameter int SAMPLE_W = 16,
    parameter int WIN_LEN  = 4,
    parameter int ENERGY_W = 32,
    parameter int RUN_W    = 8,
    parameter int SPACE_W  = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       smp_valid,
    input  logic signed [SAMPLE_W-1:0] smp_data,
    input  logic [ENERGY_W-1:0]        thr_high,
    input  logic [ENERGY_W-1:0]        thr_low,
    input  logic [RUN_W-1:0]           min_high,
    input  logic [RUN_W-1:0]           max_extra,
    input  logic [RUN_W-1:0]           max_gap,
    input  logic [RUN_W-1:0]           min_low,
    input  logic [SPACE_W-1:0]         pair_min,
    input  logic [SPACE_W-1:0]         pair_max,
    output logic                       win_valid,
    output logic [ENERGY_W-1:0]        win_energy,
    output logic                       clap_pulse,
    output logic                       lamp_on,
    output logic                       cfg_err
);
    logic cfg_ok;
    logic confirm;

    // Threshold ordering check.
    always_comb cfg_ok = (thr_high > thr_low);

    // Registered configuration error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_err <= 1'b0;
        else        cfg_err <= ~cfg_ok;
    end

    energy_window #(
        .SAMPLE_W (SAMPLE_W),
        .WIN_LEN  (WIN_LEN),
        .ENERGY_W (ENERGY_W)
    ) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_valid  (smp_valid),
        .smp_data   (smp_data),
        .win_valid  (win_valid),
        .win_energy (win_energy)
    );

    clap_sequencer #(
        .ENERGY_W (ENERGY_W),
        .RUN_W    (RUN_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_ok     (cfg_ok),
        .e_valid    (win_valid),
        .e_value    (win_energy),
        .thr_high   (thr_high),
        .thr_low    (thr_low),
        .min_high   (min_high),
        .max_extra  (max_extra),
        .max_gap    (max_gap),
        .min_low    (min_low),
        .confirm    (confirm),
        .clap_pulse (clap_pulse)
    );

    clap_pair #(
        .SPACE_W (SPACE_W)
    ) u_pair (
        .clk      (clk),
        .rst_n    (rst_n),
        .e_valid  (win_valid),
        .confirm  (confirm),
        .pair_min (pair_min),
        .pair_max (pair_max),
        .lamp_on  (lamp_on)
    );
endmodule

// File: rtl/clap_detector_chk.sv
`timescale 1ns/1ps
// clap_detector_chk
// Temporal checks on the detector's outputs, attached by bind below.
module clap_detector_chk (
    input logic clk,
    input logic rst_n,
    input logic win_valid,
    input logic clap_pulse,
    input logic lamp_on,
    input logic cfg_err
);
    // R1
    win_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |=> !win_valid);

    // R6
    clap_after_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clap_pulse |-> $past(win_valid));

    // R8
    lamp_only_on_clap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lamp_on != $past(lamp_on)) |-> clap_pulse);

    // R9
    no_clap_on_cfg_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !clap_pulse);

    // R10
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (!clap_pulse && !lamp_on && !win_valid && !cfg_err));
endmodule

bind clap_energy_detector clap_detector_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .win_valid  (win_valid),
    .clap_pulse (clap_pulse),
    .lamp_on    (lamp_on),
    .cfg_err    (cfg_err)
);

// File: tb/test_clap_energy_detector.sv
`timescale 1ns/1ps
module test_clap_energy_detector;
    localparam longint EMAX  = 64'hFFFF_FFFF;
    localparam int     SPMAX = 4095;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic signed [15:0] smp_data = '0;
    logic [31:0] thr_high = 32'd40000;
    logic [31:0] thr_low  = 32'd400;
    logic [7:0]  min_high = 8'd2, max_extra = 8'd2, max_gap = 8'd2, min_low = 8'd3;
    logic [11:0] pair_min = 12'd6, pair_max = 12'd10;
    logic        win_valid, clap_pulse, lamp_on, cfg_err;
    logic [31:0] win_energy;

    int n_chk = 0, n_fail = 0, cyc = 0, pulses = 0;
    longint last_e = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    clap_energy_detector i_clap_energy_detector (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .thr_high(thr_high), .thr_low(thr_low), .min_high(min_high),
        .max_extra(max_extra), .max_gap(max_gap), .min_low(min_low),
        .pair_min(pair_min), .pair_max(pair_max), .win_valid(win_valid),
        .win_energy(win_energy), .clap_pulse(clap_pulse), .lamp_on(lamp_on),
        .cfg_err(cfg_err));

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Behavioural reference model, updated on every rising edge.
    int     m_idx = 0, m_st = 0, m_cnt = 0, m_since = 0;
    longint m_acc = 0, m_we = 0;
    bit     m_wv = 0, m_pulse = 0, m_lamp = 0, m_pend = 0, m_cfg = 0;
    always @(posedge clk) begin : model
        bit conf, bad;
        int cls, sp;
        longint s;
        if (!rst_n) begin
            m_idx = 0; m_acc = 0; m_we = 0; m_wv = 0; m_st = 0; m_cnt = 0;
            m_pulse = 0; m_lamp = 0; m_pend = 0; m_since = 0; m_cfg = 0;
        end else begin
            conf = 0;
            bad = !(thr_high > thr_low);
            m_cfg = bad;
            if (bad) begin
                m_st = 0; m_cnt = 0;
            end else if (m_wv) begin
                cls = (m_we >= thr_high) ? 2 : (m_we <= thr_low) ? 0 : 1;
                case (m_st)
                    0: if (cls == 2) begin m_st = 1; m_cnt = 1; end
                    1: begin
                        if (cls == 2) begin
                            if (m_cnt >= min_high + max_extra) begin m_st = 4; m_cnt = 0; end
                            else m_cnt++;
                        end else if (m_cnt < min_high) begin m_st = 0; m_cnt = 0; end
                        else if (cls == 0) begin
                            if (min_low <= 1) begin conf = 1; m_st = 0; m_cnt = 0; end
                            else begin m_st = 3; m_cnt = 1; end
                        end else if (max_gap == 0) begin m_st = 0; m_cnt = 0; end
                        else begin m_st = 2; m_cnt = 1; end
                    end
                    2: begin
                        if (cls == 2) begin m_st = 0; m_cnt = 0; end
                        else if (cls == 0) begin
                            if (min_low <= 1) begin conf = 1; m_st = 0; m_cnt = 0; end
                            else begin m_st = 3; m_cnt = 1; end
                        end else if (m_cnt >= max_gap) begin m_st = 0; m_cnt = 0; end
                        else m_cnt++;
                    end
                    3: begin
                        if (cls == 0) begin
                            if (m_cnt + 1 >= min_low) begin conf = 1; m_st = 0; m_cnt = 0; end
                            else m_cnt++;
                        end else begin m_st = 0; m_cnt = 0; end
                    end
                    default: if (cls != 2) begin m_st = 0; m_cnt = 0; end
                endcase
            end
            m_pulse = conf;
            if (m_wv) begin
                sp = (m_since >= SPMAX) ? SPMAX : m_since + 1;
                if (conf) begin
                    if (m_pend && sp >= pair_min && sp <= pair_max) begin
                        m_lamp = !m_lamp; m_pend = 0;
                    end else m_pend = 1;
                    m_since = 0;
                end else m_since = sp;
            end
            m_wv = 0;
            if (smp_valid) begin
                s = smp_data;
                m_acc = m_acc + s * s;
                if (m_acc > EMAX) m_acc = EMAX;
                m_idx++;
                if (m_idx == 4) begin
                    m_we = m_acc; m_wv = 1; m_acc = 0; m_idx = 0;
                end
            end
        end
    end

    // Compare against the model away from the active edge.
    always @(negedge clk) begin
        cyc++;
        if (cyc > 2 && !done) begin
            check(win_valid == m_wv, "R1 win_valid", win_valid, m_wv);
            if (m_wv) check(win_energy == m_we, "R1/R2 win_energy", win_energy, m_we);
            check(clap_pulse == m_pulse, "R6 clap_pulse", clap_pulse, m_pulse);
            check(lamp_on == m_lamp, "R8 lamp_on", lamp_on, m_lamp);
            check(cfg_err == m_cfg, "R9 cfg_err", cfg_err, m_cfg);
        end
        if (clap_pulse) pulses++;
        if (win_valid) last_e = win_energy;
    end

    task automatic sample(input int v);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_data  = 16'(v);
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic send_window(input int amp, input bit alt);
        for (int i = 0; i < 4; i++) sample((alt && i[0]) ? -amp : amp);
    endtask

    task automatic send_pattern(input string p);
        for (int i = 0; i < p.len(); i++) begin
            if (p[i] == "H")      send_window(100, 1);
            else if (p[i] == "M") send_window(50, 1);
            else                  send_window(10, 1);
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic expect_claps(input string p, input int n, input string req);
        pulses = 0;
        send_pattern(p);
        check(pulses == n, req, pulses, n);
    endtask

    task automatic do_reset;
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check(!clap_pulse && !lamp_on && !win_valid, "R10 reset outputs", {clap_pulse, lamp_on, win_valid}, 0);
        rst_n = 1'b1;
        // R1: energy of one loud window
        send_pattern("H");
        check(last_e == 40000, "R1 window energy", last_e, 40000);
        // R2: saturation
        send_window(-32768, 0);
        repeat (2) @(negedge clk);
        check(last_e == EMAX, "R2 saturation", last_e, EMAX);
        send_pattern("LLL");
        // R3 / R6: minimal clap, and a too-short high run
        expect_claps("HHLLL", 1, "R6 basic clap");
        expect_claps("HLLL", 0, "R3 short high run");
        // R4: overrun at bound accepted, one beyond aborted
        expect_claps("HHHHLLL", 1, "R4 overrun at limit");
        expect_claps("HHHHHLLL", 0, "R4 overrun abort");
        // R5: gap at bound, gap too long, high inside gap
        expect_claps("HHMMLLL", 1, "R5 gap at limit");
        expect_claps("HHMMMLLL", 0, "R5 gap too long");
        expect_claps("HHMHLLL", 0, "R5 high in gap");
        // R6: low run interrupted
        expect_claps("HHLLMLLL", 0, "R6 low run broken");
        // R9: thresholds not ordered
        thr_low = 32'd40000;
        expect_claps("HHLLL", 0, "R9 cfg holds idle");
        check(cfg_err == 1'b1, "R9 cfg_err set", cfg_err, 1);
        thr_low = 32'd400;
        @(negedge clk);
        check(cfg_err == 1'b0, "R9 cfg_err clear", cfg_err, 0);
        // R7 / R8: pairs after a clean start
        do_reset;
        send_pattern("HHLLLHHLLL");            // spacing 5: below pair_min
        check(lamp_on == 1'b0, "R8 spacing below min", lamp_on, 0);
        send_pattern("LHHLLL");                // spacing 6: at pair_min
        check(lamp_on == 1'b1, "R7 R8 spacing at min toggles", lamp_on, 1);
        // R10: reset mid-candidate clears the lamp
        send_pattern("H");
        do_reset;
        @(negedge clk);
        check(lamp_on == 1'b0, "R10 lamp cleared", lamp_on, 0);
        send_pattern("HHLLL");
        send_pattern("LLLLLLLLLLLLLLL");
        send_pattern("HHLLL");                 // spacing 20: restart at one
        check(lamp_on == 1'b0, "R8 spacing above max", lamp_on, 0);
        send_pattern("LLLLHHLLL");             // spacing 9
        check(lamp_on == 1'b1, "R8 spacing inside", lamp_on, 1);
        send_pattern("HHLLL");                 // spacing 5, pending was consumed
        send_pattern("LLLLLHHLLL");            // spacing 10: at pair_max
        check(lamp_on == 1'b0, "R8 spacing at max toggles", lamp_on, 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule